// File: doc/BRIEF.md
# Exponential Backoff Retry Controller

This controller sits next to a compare-and-swap retry path. It turns repeated failures of one atomic operation into stall periods that get longer each time. It keeps a backoff value that starts at 1. A fail pulse starts a stall whose size comes from the current value. The value then doubles for the next attempt, unless it is already above a fixed cap, in which case it stays where it is. A success pulse puts the value back to 1.

Each stall takes one of two forms, chosen by a mode input at the moment the fail pulse is accepted:

- **Loop mode.** A down-counter is loaded with the backoff value. Each step of the counter lasts a fixed number of clock cycles, and `busy_o` stays high until the counter reaches zero.
- **Pause mode.** The block sends out one pause request for the whole amount, which is the value shifted left by a fixed number of bits. The request is a one-cycle strobe, and the loop counter is left cleared so that no counted steps follow.

Top module: `backoff_ctrl`

## Requirements
- R1: After reset, `busy_o` and `pause_req_o` are low, `pause_cyc_o` is 0, and the backoff value is 1.
- R2: A high `success_i` sets the value to 1 on the next edge. It wins over a `fail_i` in the same cycle, and that fail pulse is dropped. A stall that is already running continues to its normal end.
- R3: Each accepted fail pulse doubles the value for the next stall, as long as the value is at most LIMIT (default 4096).
- R4: An accepted fail pulse leaves the value unchanged when the value is already greater than LIMIT.
- R5: With `pause_mode_i`=0 at acceptance, `busy_o` rises in the cycle after `fail_i` is sampled. It then stays high for exactly value × ITER_CYC cycles (default ITER_CYC = 128).
- R6: With `pause_mode_i`=1 at acceptance, in the cycle after `fail_i` is sampled:
  - `pause_req_o` is high for exactly one cycle;
  - `pause_cyc_o` equals the value shifted left by PAUSE_SH (default 7) bits;
  - `busy_o` is high for that single cycle only.
- R7: `pause_cyc_o` is 0 whenever `pause_req_o` is low.
- R8: A fail pulse that arrives while `busy_o` is high is ignored. The running stall is not extended, and the value does not change.
- R9: `pause_mode_i` is only sampled when a fail pulse is accepted. Changing it during a loop stall raises no pause request and does not change the stall length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fail_i | input | 1 | Atomic attempt failed; start a stall |
| success_i | input | 1 | Atomic attempt succeeded; reset the backoff value |
| pause_mode_i | input | 1 | 1: one bulk pause request; 0: counted loop |
| busy_o | output | 1 | Stall in progress |
| pause_req_o | output | 1 | One-cycle pause request strobe |
| pause_cyc_o | output | VAL_W+PAUSE_SH | Cycle count carried with the pause request |

## Verification
The hardest case to reach is the saturation step, where the value passes the cap once and then holds. Getting there takes a long chain of back-to-back accepted failures with no success in between. The bench therefore builds the block with a small cap and a short step length. It then walks the whole doubling chain in both modes and checks every stall length and request count against a value model kept in the bench.

Fail and success pulses are also placed in the middle of running stalls. This shows that they neither shorten, extend nor restart a stall, while a success still resets the value for the next attempt.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOP  = 2'd1,
    ST_PAUSE = 2'd2
  } bo_state_e;
endpackage

// File: rtl/backoff_value.sv
module backoff_value #(
  parameter int VAL_W = 14,
  parameter int LIMIT = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             take_i,
  input  logic             clr_i,
  output logic [VAL_W-1:0] val_o
);
  logic [VAL_W-1:0] val_q;
  logic             under_cap;

  assign under_cap = (val_q <= VAL_W'(LIMIT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   val_q <= VAL_W'(1);
    else if (clr_i)                val_q <= VAL_W'(1);
    else if (take_i && under_cap)  val_q <= val_q << 1;
  end

  assign val_o = val_q;

  AST_VAL_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    val_q != '0); // R1
  AST_CLR_TO_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> val_q == VAL_W'(1)); // R2
  AST_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !clr_i && under_cap |=> val_q == ($past(val_q) << 1)); // R3
  AST_HOLD_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i && !clr_i && !under_cap |=> $stable(val_q)); // R4
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer #(
  parameter int VAL_W    = 14,
  parameter int ITER_CYC = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [VAL_W-1:0] load_val_i,
  input  logic             clear_i,
  output logic             active_o,
  output logic             last_o
);
  localparam int SUB_W = (ITER_CYC > 1) ? $clog2(ITER_CYC) : 1;
  localparam logic [SUB_W-1:0] SUB_TOP = SUB_W'(ITER_CYC - 1);

  logic [VAL_W-1:0] iter_q;
  logic [SUB_W-1:0] sub_q;

  assign active_o = (iter_q != '0);
  assign last_o   = active_o && (sub_q == '0) && (iter_q == VAL_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iter_q <= '0;
      sub_q  <= '0;
    end else if (load_i) begin
      iter_q <= load_val_i;
      sub_q  <= SUB_TOP;
    end else if (clear_i) begin
      iter_q <= '0;
      sub_q  <= '0;
    end else if (active_o) begin
      if (sub_q == '0) begin
        iter_q <= iter_q - VAL_W'(1);
        sub_q  <= SUB_TOP;
      end else begin
        sub_q <= sub_q - SUB_W'(1);
      end
    end
  end

  AST_ITER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && sub_q == '0 && !load_i && !clear_i |=> iter_q == $past(iter_q) - VAL_W'(1)); // R5
  AST_CLEAR_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i && !load_i |=> !active_o); // R6
endmodule

// File: rtl/backoff_ctrl.sv
module backoff_ctrl
  import backoff_pkg::*;
#(
  parameter int VAL_W    = 14,
  parameter int LIMIT    = 4096,
  parameter int ITER_CYC = 128,
  parameter int PAUSE_SH = 7,
  localparam int PAUSE_W = VAL_W + PAUSE_SH
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fail_i,
  input  logic               success_i,
  input  logic               pause_mode_i,
  output logic               busy_o,
  output logic               pause_req_o,
  output logic [PAUSE_W-1:0] pause_cyc_o
);
  bo_state_e        state_q, state_d;
  logic [VAL_W-1:0] val;
  logic             accept, tmr_active, tmr_last;
  logic [PAUSE_W-1:0] pcyc_q;

  // fail is taken only when idle and not overridden by success
  assign accept = (state_q == ST_IDLE) && fail_i && !success_i;

  backoff_value #(.VAL_W(VAL_W), .LIMIT(LIMIT)) u_value (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (accept),
    .clr_i  (success_i),
    .val_o  (val)
  );

  backoff_timer #(.VAL_W(VAL_W), .ITER_CYC(ITER_CYC)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && !pause_mode_i),
    .load_val_i (val),
    .clear_i    (state_q == ST_PAUSE),
    .active_o   (tmr_active),
    .last_o     (tmr_last)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = pause_mode_i ? ST_PAUSE : ST_LOOP;
      ST_LOOP:  if (tmr_last) state_d = ST_IDLE;
      ST_PAUSE: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pcyc_q  <= '0;
    end else begin
      state_q <= state_d;
      pcyc_q  <= (accept && pause_mode_i) ? (PAUSE_W'(val) << PAUSE_SH) : '0;
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign pause_req_o = (state_q == ST_PAUSE);
  assign pause_cyc_o = pcyc_q;

  AST_PAUSE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o |=> !pause_req_o && !busy_o); // R6
  AST_CYC_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_req_o |-> pause_cyc_o == '0); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && fail_i && !success_i |=> $stable(val)); // R8
  AST_LOOP_TIMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOP |-> tmr_active); // R5
  AST_LOOP_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_LOOP |=> !pause_req_o); // R9
endmodule

// File: tb/backoff_ctrl_tb_top.sv
module backoff_ctrl_tb_top;
  localparam int VAL_W = 6, LIMIT = 16, ITER = 4, SH = 7, PW = VAL_W + SH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fail_i = 1'b0, success_i = 1'b0, mode_i = 1'b0;
  logic busy_o, pause_req_o;
  logic [PW-1:0] pause_cyc_o;
  int n_run = 0, n_fail = 0, cyc = 0, v = 1;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  backoff_ctrl #(.VAL_W(VAL_W), .LIMIT(LIMIT), .ITER_CYC(ITER), .PAUSE_SH(SH)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fail_i(fail_i), .success_i(success_i),
    .pause_mode_i(mode_i), .busy_o(busy_o), .pause_req_o(pause_req_o),
    .pause_cyc_o(pause_cyc_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int grow(input int x);
    return (x > LIMIT) ? x : 2 * x;
  endfunction

  task automatic fire(input bit m);
    @(negedge clk); mode_i = m; fail_i = 1'b1;
    @(negedge clk); fail_i = 1'b0;
  endtask

  task automatic succ();
    @(negedge clk); success_i = 1'b1;
    @(negedge clk); success_i = 1'b0;
    v = 1;
  endtask

  task automatic pause_query(input string req);
    fire(1'b1);
    check({req, "_req"}, int'(pause_req_o), 1);
    check({req, "_cyc"}, int'(pause_cyc_o), v << SH);
    check({req, "_busy"}, int'(busy_o), 1);
    @(negedge clk);
    check({req, "_R6_end"}, int'(busy_o) + int'(pause_req_o), 0);
    check({req, "_R7_zero"}, int'(pause_cyc_o), 0);
    v = grow(v);
  endtask

  task automatic loop_dur(output int d);
    fire(1'b0);
    d = 0;
    while (busy_o) begin d++; @(negedge clk); end
  endtask

  initial begin
    int d, req_seen;
    #10ns rst_n = 1'b1;
    @(negedge clk);
    check("R1_busy", int'(busy_o), 0);
    check("R1_req", int'(pause_req_o), 0);
    check("R1_cyc", int'(pause_cyc_o), 0);

    // pause sweep across the doubling chain and past the cap
    for (int i = 0; i < 8; i++) begin
      if (i == 0) pause_query("R1");
      else if (v > LIMIT) pause_query("R4");
      else pause_query("R3");
    end

    succ();
    for (int i = 0; i < 7; i++) begin
      loop_dur(d);
      check((v > LIMIT) ? "R5_R4" : "R5_R3", d, v * ITER);
      v = grow(v);
    end

    // R8: fail mid-stall ignored
    succ();
    loop_dur(d); check("R5_v1", d, ITER); v = grow(v);
    fire(1'b0); d = 0;
    for (int i = 0; i < 3; i++) begin d++; @(negedge clk); end
    fail_i = 1'b1; d++; @(negedge clk); fail_i = 1'b0;
    while (busy_o) begin d++; @(negedge clk); end
    check("R8_dur", d, v * ITER); v = grow(v);
    pause_query("R8_val");

    // R2: success wins over simultaneous fail
    @(negedge clk); success_i = 1'b1; fail_i = 1'b1;
    @(negedge clk); success_i = 1'b0; fail_i = 1'b0; v = 1;
    check("R2_nostall", int'(busy_o), 0);
    pause_query("R2_val");

    // R2: success during stall does not abort it, resets value
    fire(1'b0); d = 0;
    d++; @(negedge clk);
    success_i = 1'b1; d++; @(negedge clk); success_i = 1'b0;
    while (busy_o) begin d++; @(negedge clk); end
    check("R2_dur", d, 2 * ITER); v = 1;
    pause_query("R2_after");

    // R9: mode change during loop stall
    fire(1'b0); d = 0; req_seen = 0;
    mode_i = 1'b1;
    while (busy_o) begin d++; req_seen += int'(pause_req_o); @(negedge clk); end
    check("R9_dur", d, v * ITER);
    check("R9_noreq", req_seen, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule